// File: doc/BRIEF.md
# Microcode Next-Address Sequencer

This block holds the program counter of a horizontally microcoded machine with 64-bit control words and picks the address of the next control word on every clock. Each cycle it looks at the current control word: a two-bit next-address select, the instruction category, the call-operation code and a three-bit jump condition. It then loads the program counter with one of the following: the incremented PC, a dispatch value from the ALU output register, a return PC from the call unit, or a jump target built from the control word.

Jump targets are built in three ways, chosen by the instruction category. The address category carries a full-width target. The ALU category replaces only the low 12 bits of the PC, so the jump stays inside the current 4K cluster. When the ALU category is combined with a call operation, the control word names a subroutine entry in cluster zero instead. The sequencer then raises a call-taken pulse and presents the return address for the call unit to push. Every jump taken from the control word is qualified by an eight-way condition on the carry flag, the zero flag and an indirect-jump control bit.

All outputs are registered. A stall input freezes the PC. An illegal-combination flag reports a return-PC select that is not paired with a return operation.

Top module: `useq_next_addr`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), `pc` is 0 and `call_taken`, `illegal` and `ret_addr` are 0.
- R2: While `stall` is high at a clock edge, `pc` keeps its value and `call_taken` and `illegal` are 0 after that edge.
- R3: With select `instr[57:56]` = 3, the next `pc` is `pc`+1, wrapping from 23'h7FFFFF to 0.
- R4: With select = 1 (dispatch), the next `pc` is `alu_out`, whatever the jump condition evaluates to.
- R5: With select = 2 and call operation `instr[50:48]` = 7 (return), the next `pc` is `ret_pc`, whatever the jump condition evaluates to.
- R6: With select = 2 and a call operation other than 7, `illegal` is 1 in the following cycle and `pc` advances to `pc`+1.
- R7: With select = 0, category `instr[60:58]` = 3 and a true condition, the next `pc` is `instr[22:0]`.
- R8: With select = 0, category 0, a call operation outside {4,5,6} and a true condition, the next `pc` keeps `pc[22:12]` and takes `instr[11:0]` as its low 12 bits.
- R9: With select = 0, category 0, call operation 4, 5 or 6 and a true condition, the next `pc` is `instr[11:4]` placed at bits 11..4 with all other bits 0. In the same cycle `call_taken` is 1 and `ret_addr` is the old `pc`+1.
- R10: The condition `instr[36:34]` is true for code 0 when `ind_jump`=1, 1 always, 2 when carry, 3 when not carry, 4 when zero, 5 when not zero, 6 when carry or zero, and 7 when neither carry nor zero.
- R11: With select = 0 and a false condition, the next `pc` is `pc`+1 and `call_taken` stays 0.
- R12: With select = 0 and a category other than 0 or 3, the next `pc` is `pc`+1 and `call_taken` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Hold the PC and suppress the flags |
| instr | input | 64 | Current control word |
| alu_out | input | 23 | ALU output register, dispatch target |
| ret_pc | input | 23 | Return PC offered by the call unit |
| carry | input | 1 | Carry flag |
| zero | input | 1 | Zero flag |
| ind_jump | input | 1 | Indirect-jump control bit |
| pc | output | 23 | Program counter |
| call_taken | output | 1 | Pulse: a cluster-zero call was taken |
| ret_addr | output | 23 | Return address to push on a call |
| illegal | output | 1 | Return-PC select without a return operation |

## Verification
The hardest case to reach from the ports is a cluster-local jump whose result depends on the upper PC bits left by an earlier jump. A false condition on a call must also leave `call_taken` low. The stimulus table is ordered so that a full-width jump first places a nonzero upper PC. Cluster-local jumps, calls and condition codes follow, each with flag values that make the condition both true and false. A dispatch to 23'h7FFFFF followed by an increment exercises the wrap.

// File: rtl/useq_pkg.sv
package useq_pkg;
  // Control-word field positions (decoded by neighbouring units as well)
  localparam int SEL_LO  = 56;
  localparam int CAT_LO  = 58;
  localparam int COP_LO  = 48;
  localparam int COND_LO = 34;

  typedef enum logic [1:0] {
    SEL_IR   = 2'd0,
    SEL_DISP = 2'd1,
    SEL_RPC  = 2'd2,
    SEL_NEXT = 2'd3
  } next_sel_e;

  typedef enum logic [2:0] {
    CAT_ALU  = 3'd0,
    CAT_ALUI = 3'd1,
    CAT_LDI  = 3'd2,
    CAT_ADDR = 3'd3,
    CAT_ALUX = 3'd4,
    CAT_ALUIX= 3'd5,
    CAT_RSV6 = 3'd6,
    CAT_RSV7 = 3'd7
  } cat_e;

  typedef enum logic [2:0] {
    COP_NOP   = 3'd0,
    COP_OPEN  = 3'd1,
    COP_TOPEN = 3'd2,
    COP_SPARE = 3'd3,
    COP_CALL  = 3'd4,
    COP_OCALL = 3'd5,
    COP_TCALL = 3'd6,
    COP_RET   = 3'd7
  } cop_e;

  typedef enum logic [2:0] {
    CND_IND  = 3'd0,
    CND_TRUE = 3'd1,
    CND_C    = 3'd2,
    CND_NC   = 3'd3,
    CND_Z    = 3'd4,
    CND_NZ   = 3'd5,
    CND_CZ   = 3'd6,
    CND_NCZ  = 3'd7
  } cond_e;

  function automatic logic is_call(input cop_e c);
    return (c == COP_CALL) || (c == COP_OCALL) || (c == COP_TCALL);
  endfunction
endpackage

// File: rtl/useq_cond_eval.sv
module useq_cond_eval
  import useq_pkg::*;
(
  input  cond_e code,
  input  logic  carry,
  input  logic  zero,
  input  logic  ind_jump,
  output logic  taken
);
  always_comb begin
    unique case (code)
      CND_IND:  taken = ind_jump;
      CND_TRUE: taken = 1'b1;
      CND_C:    taken = carry;
      CND_NC:   taken = ~carry;
      CND_Z:    taken = zero;
      CND_NZ:   taken = ~zero;
      CND_CZ:   taken = carry | zero;
      default:  taken = ~(carry | zero);
    endcase
  end
endmodule

// File: rtl/useq_target_sel.sv
module useq_target_sel
  import useq_pkg::*;
#(
  parameter int PC_W   = 23,
  parameter int IW     = 64,
  parameter int CL_W   = 12,
  parameter int SUB_LO = 4
) (
  input  logic [PC_W-1:0] pc,
  input  logic [IW-1:0]   instr,
  input  next_sel_e       sel,
  input  cat_e            cat,
  input  cop_e            cop,
  input  logic            taken,
  input  logic [PC_W-1:0] alu_out,
  input  logic [PC_W-1:0] ret_pc,
  output logic [PC_W-1:0] next_pc,
  output logic            call_hit,
  output logic            bad_combo
);
  logic [PC_W-1:0] pc_inc;
  logic [PC_W-1:0] cz_tgt;
  logic [PC_W-1:0] local_tgt;

  assign pc_inc = pc + 1'b1;

  always_comb begin
    cz_tgt = '0;
    cz_tgt[CL_W-1:SUB_LO] = instr[CL_W-1:SUB_LO];
  end

  assign local_tgt = {pc[PC_W-1:CL_W], instr[CL_W-1:0]};

  always_comb begin
    next_pc   = pc_inc;
    call_hit  = 1'b0;
    bad_combo = 1'b0;
    unique case (sel)
      SEL_IR: begin
        if (taken) begin
          if (cat == CAT_ADDR) begin
            next_pc = instr[PC_W-1:0];
          end else if (cat == CAT_ALU) begin
            if (is_call(cop)) begin
              next_pc  = cz_tgt;
              call_hit = 1'b1;
            end else begin
              next_pc = local_tgt;
            end
          end
        end
      end
      SEL_DISP: next_pc = alu_out;
      SEL_RPC: begin
        if (cop == COP_RET) next_pc = ret_pc;
        else                bad_combo = 1'b1;
      end
      default: next_pc = pc_inc;
    endcase
  end
endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
  import useq_pkg::*;
#(
  parameter int PC_W   = 23,
  parameter int IW     = 64,
  parameter int CL_W   = 12,
  parameter int SUB_LO = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            stall,
  input  logic [IW-1:0]   instr,
  input  logic [PC_W-1:0] alu_out,
  input  logic [PC_W-1:0] ret_pc,
  input  logic            carry,
  input  logic            zero,
  input  logic            ind_jump,
  output logic [PC_W-1:0] pc,
  output logic            call_taken,
  output logic [PC_W-1:0] ret_addr,
  output logic            illegal
);
  next_sel_e       sel;
  cat_e            cat;
  cop_e            cop;
  cond_e           cnd;
  logic            taken;
  logic [PC_W-1:0] nxt;
  logic            call_hit;
  logic            bad_combo;

  assign sel = next_sel_e'(instr[SEL_LO +: 2]);
  assign cat = cat_e'(instr[CAT_LO +: 3]);
  assign cop = cop_e'(instr[COP_LO +: 3]);
  assign cnd = cond_e'(instr[COND_LO +: 3]);

  useq_cond_eval u_cond (
    .code     (cnd),
    .carry    (carry),
    .zero     (zero),
    .ind_jump (ind_jump),
    .taken    (taken)
  );

  useq_target_sel #(
    .PC_W(PC_W), .IW(IW), .CL_W(CL_W), .SUB_LO(SUB_LO)
  ) u_tgt (
    .pc        (pc),
    .instr     (instr),
    .sel       (sel),
    .cat       (cat),
    .cop       (cop),
    .taken     (taken),
    .alu_out   (alu_out),
    .ret_pc    (ret_pc),
    .next_pc   (nxt),
    .call_hit  (call_hit),
    .bad_combo (bad_combo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc         <= '0;
      call_taken <= 1'b0;
      illegal    <= 1'b0;
      ret_addr   <= '0;
    end else if (stall) begin
      call_taken <= 1'b0;
      illegal    <= 1'b0;
    end else begin
      pc         <= nxt;
      call_taken <= call_hit;
      illegal    <= bad_combo;
      if (call_hit) ret_addr <= pc + 1'b1;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (pc == '0 && !call_taken && !illegal)); // R1
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    stall |=> ($stable(pc) && !call_taken && !illegal)); // R2
  AST_DISPATCH: assert property (@(posedge clk) disable iff (rst)
    (!stall && sel == SEL_DISP) |=> pc == $past(alu_out)); // R4
  AST_RETURN: assert property (@(posedge clk) disable iff (rst)
    (!stall && sel == SEL_RPC && cop == COP_RET) |=> pc == $past(ret_pc)); // R5
  AST_COND_FALSE: assert property (@(posedge clk) disable iff (rst)
    (!stall && sel == SEL_IR && !taken) |=> (pc == $past(pc) + 1'b1 && !call_taken)); // R11
  AST_CALL_SHAPE: assert property (@(posedge clk) disable iff (rst)
    call_taken |-> (pc[PC_W-1:CL_W] == '0 && pc[SUB_LO-1:0] == '0)); // R9
endmodule

// File: tb/useq_next_addr_bench.sv
module useq_next_addr_bench;
  localparam int PC_W = 23;

  logic            clk = 1'b0;
  logic            rst, stall, carry, zero, ind_jump;
  logic [63:0]     instr;
  logic [PC_W-1:0] alu_out, ret_pc, pc, ret_addr;
  logic            call_taken, illegal;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  useq_next_addr u_useq_next_addr (
    .clk(clk), .rst(rst), .stall(stall), .instr(instr),
    .alu_out(alu_out), .ret_pc(ret_pc), .carry(carry), .zero(zero),
    .ind_jump(ind_jump), .pc(pc), .call_taken(call_taken),
    .ret_addr(ret_addr), .illegal(illegal)
  );

  typedef struct packed {
    logic [1:0]  sel;
    logic [2:0]  cat;
    logic [2:0]  cop;
    logic [2:0]  cnd;
    logic [2:0]  flg;   // {carry, zero, ind_jump}
    logic [22:0] fld;
    logic [22:0] alu;
    logic [22:0] rpc;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t TBL [NV] = '{
    '{2'd3, 3'd0, 3'd0, 3'd1, 3'b000, 23'h0,      23'h0,      23'h0},      // R3
    '{2'd1, 3'd0, 3'd0, 3'd2, 3'b000, 23'h0,      23'h4A5F3C, 23'h0},      // R4 cond false ignored
    '{2'd0, 3'd3, 3'd0, 3'd1, 3'b000, 23'h123456, 23'h0,      23'h0},      // R7
    '{2'd0, 3'd0, 3'd0, 3'd1, 3'b000, 23'h000ABC, 23'h0,      23'h0},      // R8
    '{2'd0, 3'd0, 3'd4, 3'd1, 3'b000, 23'h0005D7, 23'h0,      23'h0},      // R9
    '{2'd0, 3'd0, 3'd5, 3'd4, 3'b010, 23'h000FFF, 23'h0,      23'h0},      // R9 R10 zero
    '{2'd0, 3'd3, 3'd0, 3'd0, 3'b001, 23'h7F0001, 23'h0,      23'h0},      // R10 indirect
    '{2'd0, 3'd3, 3'd0, 3'd0, 3'b000, 23'h111111, 23'h0,      23'h0},      // R11
    '{2'd0, 3'd3, 3'd0, 3'd3, 3'b000, 23'h000111, 23'h0,      23'h0},      // R10 not carry
    '{2'd0, 3'd0, 3'd6, 3'd5, 3'b010, 23'h000444, 23'h0,      23'h0},      // R11 call skipped
    '{2'd0, 3'd0, 3'd6, 3'd6, 3'b100, 23'h000321, 23'h0,      23'h0},      // R10 R9
    '{2'd0, 3'd3, 3'd0, 3'd7, 3'b000, 23'h2AAAAA, 23'h0,      23'h0},      // R10
    '{2'd0, 3'd3, 3'd0, 3'd7, 3'b010, 23'h555555, 23'h0,      23'h0},      // R11
    '{2'd2, 3'd0, 3'd7, 3'd2, 3'b000, 23'h0,      23'h0,      23'h0ABCDE}, // R5
    '{2'd2, 3'd0, 3'd1, 3'd1, 3'b000, 23'h0,      23'h0,      23'h033333}, // R6
    '{2'd0, 3'd1, 3'd0, 3'd1, 3'b000, 23'h001234, 23'h0,      23'h0},      // R12
    '{2'd0, 3'd4, 3'd0, 3'd1, 3'b000, 23'h000777, 23'h0,      23'h0},      // R12
    '{2'd0, 3'd2, 3'd4, 3'd1, 3'b000, 23'h000880, 23'h0,      23'h0},      // R12
    '{2'd1, 3'd0, 3'd0, 3'd1, 3'b000, 23'h0,      23'h7FFFFF, 23'h0},      // R4
    '{2'd3, 3'd0, 3'd0, 3'd1, 3'b000, 23'h0,      23'h0,      23'h0},      // R3 wrap
    '{2'd2, 3'd0, 3'd0, 3'd1, 3'b000, 23'h0,      23'h0,      23'h0}       // R6
  };

  function automatic logic [63:0] mk_instr(input vec_t v);
    logic [63:0] w = 64'h0;
    w[57:56] = v.sel;
    w[60:58] = v.cat;
    w[50:48] = v.cop;
    w[36:34] = v.cnd;
    w[22:0]  = v.fld;
    return w;
  endfunction

  function automatic logic cond_ref(input logic [2:0] c, input logic [2:0] f);
    case (c)
      3'd0: return f[0];
      3'd1: return 1'b1;
      3'd2: return f[2];
      3'd3: return !f[2];
      3'd4: return f[1];
      3'd5: return !f[1];
      3'd6: return f[2] || f[1];
      default: return !(f[2] || f[1]);
    endcase
  endfunction

  task automatic ref_step(input logic [22:0] p, input vec_t v,
                          output logic [22:0] np, output logic cl, output logic il);
    np = p + 23'd1; cl = 1'b0; il = 1'b0;
    case (v.sel)
      2'd0: if (cond_ref(v.cnd, v.flg)) begin
        if (v.cat == 3'd3) np = v.fld;
        else if (v.cat == 3'd0) begin
          if (v.cop >= 3'd4 && v.cop <= 3'd6) begin
            np = {11'd0, v.fld[11:4], 4'd0}; cl = 1'b1;
          end else np = {p[22:12], v.fld[11:0]};
        end
      end
      2'd1: np = v.alu;
      2'd2: if (v.cop == 3'd7) np = v.rpc; else il = 1'b1;
      default: ;
    endcase
  endtask

  task automatic chk(input string tag, input logic [22:0] act, input logic [22:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    instr = mk_instr(v); alu_out = v.alu; ret_pc = v.rpc;
    carry = v.flg[2]; zero = v.flg[1]; ind_jump = v.flg[0];
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [22:0] p_before, exp_pc;
    logic        exp_cl, exp_il;
    vec_t        v;
    rst = 1'b1; stall = 1'b0; instr = '0; alu_out = '0; ret_pc = '0;
    carry = 1'b0; zero = 1'b0; ind_jump = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 pc", pc, 23'd0);
    chk("R1 call_taken", {22'd0, call_taken}, 23'd0);
    chk("R1 illegal", {22'd0, illegal}, 23'd0);
    chk("R1 ret_addr", ret_addr, 23'd0);
    @(negedge clk); rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      v = TBL[i];
      apply(v);
      p_before = pc;
      ref_step(p_before, v, exp_pc, exp_cl, exp_il);
      @(posedge clk); #1;
      chk($sformatf("R3-12 vec%0d pc", i), pc, exp_pc);
      chk($sformatf("R9 vec%0d call_taken", i), {22'd0, call_taken}, {22'd0, exp_cl});
      chk($sformatf("R6 vec%0d illegal", i), {22'd0, illegal}, {22'd0, exp_il});
      if (exp_cl) chk($sformatf("R9 vec%0d ret_addr", i), ret_addr, p_before + 23'd1);
    end

    // R2: stall holds pc and suppresses flags while a call and an illegal are offered
    @(negedge clk);
    v = TBL[4];  // call in cluster zero
    apply(v);
    stall = 1'b1;
    p_before = pc;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1;
      chk("R2 pc hold", pc, p_before);
      chk("R2 call_taken low", {22'd0, call_taken}, 23'd0);
    end
    @(negedge clk);
    v = TBL[14]; apply(v);
    @(posedge clk); #1;
    chk("R2 illegal low", {22'd0, illegal}, 23'd0);
    chk("R2 pc hold", pc, p_before);
    @(negedge clk); stall = 1'b0;
    @(posedge clk); #1;
    chk("R6 after stall pc", pc, p_before + 23'd1);
    chk("R6 after stall illegal", {22'd0, illegal}, 23'd1);

    // R8 upper bits preserved from a high cluster
    @(negedge clk);
    v = TBL[0]; v.sel = 2'd1; v.alu = 23'h6AB123; apply(v);
    @(posedge clk); #1;
    chk("R4 dispatch", pc, 23'h6AB123);
    @(negedge clk);
    v = TBL[3]; v.fld = 23'h7FFFFF; apply(v);
    @(posedge clk); #1;
    chk("R8 cluster jump", pc, 23'h6ABFFF);

    // R1 reset mid-run
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    chk("R1 mid-run pc", pc, 23'd0);
    chk("R1 mid-run illegal", {22'd0, illegal}, 23'd0);
    @(negedge clk); rst = 1'b0;

    finish_run();
  end
endmodule